// File: doc/BRIEF.md
# Four-Core Local Interrupt Router

This block sits beside a cluster of four processor cores. It collects each core's private interrupt sources: four timer lines, four mailbox lines and one performance-monitor line. It also collects one external interrupt that all cores share. For every core it drives a normal interrupt request (IRQ) and a fast interrupt request (FIQ). Software programs the router through a simple single-cycle register port. Writes are registered, and reads are combinational from the address.

Each timer and mailbox source has one enable bit for IRQ and one for FIQ. An enabled FIQ wins over an enabled IRQ, so a source never appears in both directions. The shared external interrupt is steered to one core as IRQ or to one core as FIQ, under the control of one routing register. Performance-monitor enables are changed only through a set register and a clear register, so each core's enable can be changed without a read-modify-write.

Every core has a read-only IRQ-pending word and a read-only FIQ-pending word. Both show live input levels masked by the enables. A core's output line is asserted whenever its matching pending word is non-zero. The path from the interrupt inputs to the outputs holds no register.

Top module: `core_irq_router`

## Requirements
- R1: After reset all routing and enable state is zero. Both outputs of every core stay low whatever the input levels, and every register reads back zero.
- R2: Each core's timer control word is at 0x40 + 4*core. Bit k (k = 0..3) enables timer source k as IRQ, and bit 4+k enables it as FIQ. When bit 4+k is set, the source goes to FIQ and is removed from IRQ. Timer source k shows in pending bit k.
- R3: Each core's mailbox control word is at 0x50 + 4*core and has the same bit layout as the timer word. Mailbox k shows in pending bit 4+k.
- R4: The routing register is at 0x0C and uses these fields: [1:0] IRQ core, [3:2] FIQ core, [4] external IRQ enable, [5] external FIQ enable. When [5] is set, the external interrupt goes only to the FIQ word of core [3:2]. When only [4] is set, it goes only to the IRQ word of core [1:0]. It shows in pending bit 8, on at most one core.
- R5: The performance-monitor set register is at 0x10 and the clear register is at 0x14. Writing 1 to bit n sets (at 0x10) or clears (at 0x14) core n's enable. Writing 0 to a bit leaves it unchanged. Both addresses read back the enable mask in bits [3:0]. An enabled performance-monitor input shows in IRQ-pending bit 9 and never in FIQ.
- R6: The IRQ-pending words are at 0x60 + 4*core and the FIQ-pending words are at 0x70 + 4*core. Each pending word holds its data in bits [9:0] and reads zero above them. Writes to a pending address change nothing.
- R7: A core's IRQ output equals the OR of its IRQ-pending word, and its FIQ output equals the OR of its FIQ-pending word. Both follow input changes in the same cycle, with no clock edge.
- R8: No source is ever present in both pending words of a core.
- R9: Address bits [1:0] are ignored. Reads of unmapped addresses return zero, and writes to unmapped addresses change nothing.
- R10: A register write takes effect at the clock edge that samples it, and read data reflects the old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| timer_irq_i | input | 16 | Timer lines, 4 per core, core c at [4c+3:4c] |
| mbox_irq_i | input | 16 | Mailbox lines, 4 per core, core c at [4c+3:4c] |
| ext_irq_i | input | 1 | Shared external interrupt level |
| pmu_irq_i | input | 4 | Performance-monitor line per core |
| core_irq_o | output | 4 | IRQ request per core |
| core_fiq_o | output | 4 | FIQ request per core |

## Verification
The bench sweeps all 256 values of every core's timer word and of every core's mailbox word against all 16 input patterns. A design that let IRQ leak through while FIQ was enabled, or that wired a bit to the wrong slot, would show a wrong bit in one of the two pending words. All 64 routing values are swept with the external line both low and high. A router that ignored the FIQ priority, or that sent the interrupt to a core index off by one, would flag the wrong core, or two cores at once.

A sequence of set and clear writes, including all-zero writes, would catch a set register that assigns the mask instead of ORing into it, and a clear register that does not honour write-zero. Further checks write to the pending addresses, use unaligned and unmapped addresses, and read during the write cycle. These expose a writable status word, address decoding that depends on the low bits, and read data that shows a write too early.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;

    localparam int SRC_PER_GRP = 4;
    localparam int CTL_W       = 2 * SRC_PER_GRP;
    localparam int PEND_W      = 10;

    localparam logic [7:0] OFS_ROUTE   = 8'h0C;
    localparam logic [7:0] OFS_PMU_SET = 8'h10;
    localparam logic [7:0] OFS_PMU_CLR = 8'h14;
    localparam logic [7:0] OFS_TMR     = 8'h40;
    localparam logic [7:0] OFS_MBX     = 8'h50;
    localparam logic [7:0] OFS_IRQP    = 8'h60;
    localparam logic [7:0] OFS_FIQP    = 8'h70;

    localparam int BIT_TMR = 0;
    localparam int BIT_MBX = 4;
    localparam int BIT_EXT = 8;
    localparam int BIT_PMU = 9;

    function automatic logic [7:0] core_ofs(input logic [7:0] base, input int idx);
        return base + 8'(idx * 4);
    endfunction

    // sources enabled for IRQ whose FIQ enable is clear
    function automatic logic [SRC_PER_GRP-1:0] grp_irq(input logic [SRC_PER_GRP-1:0] src,
                                                       input logic [CTL_W-1:0] ctl);
        return src & ctl[SRC_PER_GRP-1:0] & ~ctl[CTL_W-1:SRC_PER_GRP];
    endfunction

    function automatic logic [SRC_PER_GRP-1:0] grp_fiq(input logic [SRC_PER_GRP-1:0] src,
                                                       input logic [CTL_W-1:0] ctl);
        return src & ctl[CTL_W-1:SRC_PER_GRP];
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import core_irq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    localparam int SEL_W    = $clog2(NUM_CORES),
    localparam int RT_W     = 2 * SEL_W + 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [RT_W-1:0]                   route_q,
    output logic [NUM_CORES-1:0]              pmu_en_q,
    output logic [NUM_CORES-1:0][CTL_W-1:0]   tmr_ctl_q,
    output logic [NUM_CORES-1:0][CTL_W-1:0]   mbx_ctl_q
);

    typedef struct packed {
        logic [RT_W-1:0]                 route;
        logic [NUM_CORES-1:0]            pmu_en;
        logic [NUM_CORES-1:0][CTL_W-1:0] tmr;
        logic [NUM_CORES-1:0][CTL_W-1:0] mbx;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [ADDR_W-1:0] word;
    logic              unused_bits;

    assign word        = {addr[ADDR_W-1:2], 2'b00};
    assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:CTL_W]};

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (word == ADDR_W'(OFS_ROUTE)) begin
                cfg_d.route = wdata[RT_W-1:0];
            end
            if (word == ADDR_W'(OFS_PMU_SET)) begin
                cfg_d.pmu_en = cfg_q.pmu_en | wdata[NUM_CORES-1:0];
            end
            if (word == ADDR_W'(OFS_PMU_CLR)) begin
                cfg_d.pmu_en = cfg_q.pmu_en & ~wdata[NUM_CORES-1:0];
            end
            for (int c = 0; c < NUM_CORES; c++) begin
                if (word == ADDR_W'(core_ofs(OFS_TMR, c))) begin
                    cfg_d.tmr[c] = wdata[CTL_W-1:0];
                end
                if (word == ADDR_W'(core_ofs(OFS_MBX, c))) begin
                    cfg_d.mbx[c] = wdata[CTL_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign route_q   = cfg_q.route;
    assign pmu_en_q  = cfg_q.pmu_en;
    assign tmr_ctl_q = cfg_q.tmr;
    assign mbx_ctl_q = cfg_q.mbx;

endmodule

// File: rtl/irq_core_slice.sv
module irq_core_slice
    import core_irq_pkg::*;
#(
    parameter int CORE_IDX = 0,
    parameter int SEL_W    = 2,
    localparam int RT_W    = 2 * SEL_W + 2
) (
    input  logic [SRC_PER_GRP-1:0] tmr_in,
    input  logic [SRC_PER_GRP-1:0] mbx_in,
    input  logic                   ext_in,
    input  logic                   pmu_in,
    input  logic [CTL_W-1:0]       tmr_ctl,
    input  logic [CTL_W-1:0]       mbx_ctl,
    input  logic [RT_W-1:0]        route,
    input  logic                   pmu_en,
    output logic [PEND_W-1:0]      irq_pend,
    output logic [PEND_W-1:0]      fiq_pend,
    output logic                   irq_o,
    output logic                   fiq_o
);

    logic ext_irq_en, ext_fiq_en, irq_here, fiq_here;
    logic ext_irq, ext_fiq;

    assign ext_irq_en = route[2*SEL_W];
    assign ext_fiq_en = route[2*SEL_W+1];
    assign irq_here   = (route[SEL_W-1:0] == SEL_W'(CORE_IDX));
    assign fiq_here   = (route[2*SEL_W-1:SEL_W] == SEL_W'(CORE_IDX));

    // FIQ routing wins: with its enable set, the IRQ path is closed for every core
    assign ext_fiq = ext_in & ext_fiq_en & fiq_here;
    assign ext_irq = ext_in & ext_irq_en & ~ext_fiq_en & irq_here;

    always_comb begin
        irq_pend = '0;
        fiq_pend = '0;
        irq_pend[BIT_TMR +: SRC_PER_GRP] = grp_irq(tmr_in, tmr_ctl);
        fiq_pend[BIT_TMR +: SRC_PER_GRP] = grp_fiq(tmr_in, tmr_ctl);
        irq_pend[BIT_MBX +: SRC_PER_GRP] = grp_irq(mbx_in, mbx_ctl);
        fiq_pend[BIT_MBX +: SRC_PER_GRP] = grp_fiq(mbx_in, mbx_ctl);
        irq_pend[BIT_EXT]                = ext_irq;
        fiq_pend[BIT_EXT]                = ext_fiq;
        irq_pend[BIT_PMU]                = pmu_in & pmu_en;
    end

    assign irq_o = |irq_pend;
    assign fiq_o = |fiq_pend;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import core_irq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    localparam int SEL_W    = $clog2(NUM_CORES),
    localparam int RT_W     = 2 * SEL_W + 2
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [RT_W-1:0]                  route,
    input  logic [NUM_CORES-1:0]             pmu_en,
    input  logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl,
    input  logic [NUM_CORES-1:0][CTL_W-1:0]  mbx_ctl,
    input  logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend,
    input  logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend,
    output logic [DATA_W-1:0]                rdata
);

    logic [ADDR_W-1:0] word;
    logic              unused_lo;

    assign word      = {addr[ADDR_W-1:2], 2'b00};
    assign unused_lo = ^addr[1:0];

    always_comb begin
        rdata = '0;
        if (word == ADDR_W'(OFS_ROUTE)) begin
            rdata[RT_W-1:0] = route;
        end
        if (word == ADDR_W'(OFS_PMU_SET) || word == ADDR_W'(OFS_PMU_CLR)) begin
            rdata[NUM_CORES-1:0] = pmu_en;
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (word == ADDR_W'(core_ofs(OFS_TMR, c)))  rdata[CTL_W-1:0]  = tmr_ctl[c];
            if (word == ADDR_W'(core_ofs(OFS_MBX, c)))  rdata[CTL_W-1:0]  = mbx_ctl[c];
            if (word == ADDR_W'(core_ofs(OFS_IRQP, c))) rdata[PEND_W-1:0] = irq_pend[c];
            if (word == ADDR_W'(core_ofs(OFS_FIQP, c))) rdata[PEND_W-1:0] = fiq_pend[c];
        end
    end

endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
    import core_irq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    localparam int SEL_W    = $clog2(NUM_CORES),
    localparam int RT_W     = 2 * SEL_W + 2,
    localparam int GRP_W    = NUM_CORES * SRC_PER_GRP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [GRP_W-1:0]     timer_irq_i,
    input  logic [GRP_W-1:0]     mbox_irq_i,
    input  logic                 ext_irq_i,
    input  logic [NUM_CORES-1:0] pmu_irq_i,
    output logic [NUM_CORES-1:0] core_irq_o,
    output logic [NUM_CORES-1:0] core_fiq_o
);

    logic [RT_W-1:0]                  route_q;
    logic [NUM_CORES-1:0]             pmu_en_q;
    logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl_q;
    logic [NUM_CORES-1:0][CTL_W-1:0]  mbx_ctl_q;
    logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend_all;
    logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend_all;

    irq_cfg_regs #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .route_q   (route_q),
        .pmu_en_q  (pmu_en_q),
        .tmr_ctl_q (tmr_ctl_q),
        .mbx_ctl_q (mbx_ctl_q)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        irq_core_slice #(
            .CORE_IDX (c),
            .SEL_W    (SEL_W)
        ) u_slice (
            .tmr_in   (timer_irq_i[c*SRC_PER_GRP +: SRC_PER_GRP]),
            .mbx_in   (mbox_irq_i[c*SRC_PER_GRP +: SRC_PER_GRP]),
            .ext_in   (ext_irq_i),
            .pmu_in   (pmu_irq_i[c]),
            .tmr_ctl  (tmr_ctl_q[c]),
            .mbx_ctl  (mbx_ctl_q[c]),
            .route    (route_q),
            .pmu_en   (pmu_en_q[c]),
            .irq_pend (irq_pend_all[c]),
            .fiq_pend (fiq_pend_all[c]),
            .irq_o    (core_irq_o[c]),
            .fiq_o    (core_fiq_o[c])
        );
    end

    irq_read_mux #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_rmux (
        .addr     (reg_addr),
        .route    (route_q),
        .pmu_en   (pmu_en_q),
        .tmr_ctl  (tmr_ctl_q),
        .mbx_ctl  (mbx_ctl_q),
        .irq_pend (irq_pend_all),
        .fiq_pend (fiq_pend_all),
        .rdata    (reg_rdata)
    );

endmodule

// File: rtl/core_irq_router_chk.sv
module core_irq_router_chk
    import core_irq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8,
    localparam int GRP_W    = NUM_CORES * SRC_PER_GRP
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                addr,
    input logic [NUM_CORES-1:0]             wdata_lo,
    input logic [NUM_CORES-1:0]             pmu_en,
    input logic [GRP_W-1:0]                 tmr_in,
    input logic [NUM_CORES-1:0][CTL_W-1:0]  tmr_ctl,
    input logic                             ext_in,
    input logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend,
    input logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend,
    input logic [NUM_CORES-1:0]             core_fiq_o
);

    logic [ADDR_W-1:0]    word;
    logic                 hit_set, hit_clr;
    logic [NUM_CORES-1:0] ext_hits;

    assign word    = {addr[ADDR_W-1:2], 2'b00};
    assign hit_set = wr_en && (word == ADDR_W'(OFS_PMU_SET));
    assign hit_clr = wr_en && (word == ADDR_W'(OFS_PMU_CLR));

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
        assign ext_hits[c] = irq_pend[c][BIT_EXT] | fiq_pend[c][BIT_EXT];

        // R8: a source never sits in both words
        p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_pend[c] & fiq_pend[c]) == '0);

        // R2: an FIQ-enabled active timer raises FIQ and stays out of IRQ
        p_tmr_fiq_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (|(tmr_in[c*SRC_PER_GRP +: SRC_PER_GRP] & tmr_ctl[c][CTL_W-1:SRC_PER_GRP]))
            |-> core_fiq_o[c]);
        p_tmr_ovr_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_ctl[c][CTL_W-1:SRC_PER_GRP] & irq_pend[c][BIT_TMR +: SRC_PER_GRP]) == '0);

        // R5: write-one set and clear, write-zero keeps
        p_pmu_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_set && wdata_lo[c]) |=> pmu_en[c]);
        p_pmu_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_clr && wdata_lo[c]) |=> !pmu_en[c]);
        p_pmu_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((hit_set || hit_clr) && !wdata_lo[c]) |=> (pmu_en[c] == $past(pmu_en[c])));
    end

    // R4: the external interrupt lands on at most one core, and only when active
    p_ext_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_hits));
    p_ext_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_in |-> (ext_hits == '0));

endmodule

bind core_irq_router core_irq_router_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .addr       (reg_addr),
    .wdata_lo   (reg_wdata[NUM_CORES-1:0]),
    .pmu_en     (pmu_en_q),
    .tmr_in     (timer_irq_i),
    .tmr_ctl    (tmr_ctl_q),
    .ext_in     (ext_irq_i),
    .irq_pend   (irq_pend_all),
    .fiq_pend   (fiq_pend_all),
    .core_fiq_o (core_fiq_o)
);

// File: tb/sim_core_irq_router.sv
`timescale 1ns/1ps
module sim_core_irq_router;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] timer_irq_i = '0;
    logic [15:0] mbox_irq_i = '0;
    logic        ext_irq_i = 1'b0;
    logic [3:0]  pmu_irq_i = '0;
    logic [3:0]  core_irq_o, core_fiq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    core_irq_router u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .timer_irq_i (timer_irq_i),
        .mbox_irq_i  (mbox_irq_i),
        .ext_irq_i   (ext_irq_i),
        .pmu_irq_i   (pmu_irq_i),
        .core_irq_o  (core_irq_o),
        .core_fiq_o  (core_fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(2 * HALF * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog act=timeout exp=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything disabled out of reset
        @(negedge clk);
        timer_irq_i = '1; mbox_irq_i = '1; ext_irq_i = 1'b1; pmu_irq_i = '1;
        #1;
        chk("R1 irq out", 32'(core_irq_o), 32'h0);
        chk("R1 fiq out", 32'(core_fiq_o), 32'h0);
        for (int a = 0; a < 256; a += 4) begin
            rd(8'(a), d);
            chk("R1 readback", d, 32'h0);
        end
        timer_irq_i = '0; mbox_irq_i = '0; ext_irq_i = 1'b0; pmu_irq_i = '0;

        // R2 / R3 / R7 / R8: timer and mailbox word sweeps
        for (int grp = 0; grp < 2; grp++) begin
            for (int c = 0; c < 4; c++) begin
                for (int v = 0; v < 256; v++) begin
                    wr(8'((grp == 0 ? 8'h40 : 8'h50) + 4 * c), 32'(v));
                    for (int p = 0; p < 16; p++) begin
                        logic [3:0] ei, ef;
                        logic [9:0] wi, wf;
                        ei = 4'(p) & 4'(v) & ~4'(v >> 4);
                        ef = 4'(p) & 4'(v >> 4);
                        wi = (grp == 0) ? 10'(ei) : 10'(ei) << 4;
                        wf = (grp == 0) ? 10'(ef) : 10'(ef) << 4;
                        @(negedge clk);
                        if (grp == 0) timer_irq_i = {4{4'(p)}};
                        else          mbox_irq_i  = {4{4'(p)}};
                        rd(8'(8'h60 + 4 * c), d);
                        chk(grp == 0 ? "R2 irq pend" : "R3 irq pend", d, 32'(wi));
                        rd(8'(8'h70 + 4 * c), d);
                        chk(grp == 0 ? "R2 fiq pend" : "R3 fiq pend", d, 32'(wf));
                        chk("R7 R8 outputs", {24'h0, core_fiq_o, core_irq_o},
                            {24'h0, 4'((ef != 0) << c), 4'((ei != 0) << c)});
                    end
                end
                wr(8'((grp == 0 ? 8'h40 : 8'h50) + 4 * c), 32'h0);
            end
            timer_irq_i = '0;
            mbox_irq_i  = '0;
        end

        // R4: every routing value, external line low and high
        for (int r = 0; r < 64; r++) begin
            wr(8'h0C, 32'(r));
            rd(8'h0C, d);
            chk("R4 route readback", d, 32'(r));
            for (int e = 0; e < 2; e++) begin
                logic [3:0] xi, xf;
                for (int c = 0; c < 4; c++) begin
                    xf[c] = (e == 1) && r[5] && (r[3:2] == 2'(c));
                    xi[c] = (e == 1) && r[4] && !r[5] && (r[1:0] == 2'(c));
                end
                @(negedge clk);
                ext_irq_i = 1'(e);
                for (int c = 0; c < 4; c++) begin
                    rd(8'(8'h60 + 4 * c), d);
                    chk("R4 ext irq pend", d, 32'(xi[c]) << 8);
                    rd(8'(8'h70 + 4 * c), d);
                    chk("R4 ext fiq pend", d, 32'(xf[c]) << 8);
                end
                chk("R4 R7 ext outputs", {24'h0, core_fiq_o, core_irq_o}, {24'h0, xf, xi});
            end
        end
        wr(8'h0C, 32'h0);
        ext_irq_i = 1'b0;

        // R5: set/clear sequence with all performance-monitor lines active
        pmu_irq_i = 4'hF;
        begin
            logic [3:0] mask;
            logic [31:0] seq_d [6];
            bit          seq_s [6];
            seq_d = '{32'h5, 32'h0, 32'h1, 32'h0, 32'hA, 32'hFFFF_FFF6};
            seq_s = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
            mask = 4'h0;
            for (int i = 0; i < 6; i++) begin
                wr(seq_s[i] ? 8'h10 : 8'h14, seq_d[i]);
                mask = seq_s[i] ? (mask | seq_d[i][3:0]) : (mask & ~seq_d[i][3:0]);
                rd(8'h10, d);
                chk("R5 mask via set addr", d, 32'(mask));
                rd(8'h14, d);
                chk("R5 mask via clr addr", d, 32'(mask));
                chk("R5 irq out", 32'(core_irq_o), 32'(mask));
                chk("R5 no fiq", 32'(core_fiq_o), 32'h0);
                for (int c = 0; c < 4; c++) begin
                    rd(8'(8'h60 + 4 * c), d);
                    chk("R5 pend bit9", d, 32'(mask[c]) << 9);
                    rd(8'(8'h70 + 4 * c), d);
                    chk("R5 fiq pend", d, 32'h0);
                end
            end
        end
        wr(8'h14, 32'hF);
        pmu_irq_i = '0;

        // R6: pending words ignore writes and stay live
        wr(8'h40, 32'h0F);
        wr(8'h60, 32'h3FF);
        wr(8'h70, 32'h3FF);
        rd(8'h60, d); chk("R6 irq pend after write", d, 32'h0);
        rd(8'h70, d); chk("R6 fiq pend after write", d, 32'h0);
        chk("R6 outputs quiet", {24'h0, core_fiq_o, core_irq_o}, 32'h0);
        rd(8'h40, d); chk("R6 timer word intact", d, 32'h0F);
        rd(8'h50, d); chk("R6 mailbox word intact", d, 32'h0);
        timer_irq_i = 16'hFFF1;
        #1;
        rd(8'h60, d); chk("R6 live pend", d, 32'h001);
        timer_irq_i = '0;
        wr(8'h40, 32'h0);

        // R9: low address bits ignored, unmapped space inert
        wr(8'h47, 32'hC3);
        rd(8'h44, d); chk("R9 unaligned write lands", d, 32'hC3);
        rd(8'h46, d); chk("R9 unaligned read", d, 32'hC3);
        rd(8'h40, d); chk("R9 neighbour untouched", d, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h20, d); chk("R9 unmapped read", d, 32'h0);
        rd(8'h80, d); chk("R9 unmapped read hi", d, 32'h0);
        rd(8'h0C, d); chk("R9 route untouched", d, 32'h0);
        rd(8'h10, d); chk("R9 pmu untouched", d, 32'h0);
        wr(8'h44, 32'h0);

        // R10: read shows old value until the sampling edge
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = 8'h54;
        reg_wdata = 32'h5A;
        #1;
        chk("R10 before edge", reg_rdata, 32'h0);
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
        chk("R10 after edge", reg_rdata, 32'h5A);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule